// File: doc/BRIEF.md
# Receive Buffer Closing Controller

This block sits behind a serial character receiver and packs each incoming character into one of a ring of fixed-size memory buffers. Every accepted character goes out on a simple write port whose address joins the current buffer index with the character's offset in that buffer. The block counts how many bytes the open buffer holds. It also counts how many idle characters have arrived in a row.

A buffer is closed, and reception moves to the next buffer in the ring, in four cases. The first is a character that equals a programmed control value. The second is a character that arrives with any receive error flag. The third is the character that fills the buffer. The fourth is a programmed number of consecutive idle characters. Each close produces a one-cycle status word that gives the reasons for the close, the error flags and the byte count, together with the index of the closed buffer. When the interrupt enable is set, each close also produces a one-cycle interrupt pulse.

Top module: `rxBufCloser`

## Requirements
- R1: While reset is held and in the first cycle after it, wrEn, closeValid and irq are 0. The first buffer used after reset has index 0.
- R2: A character presented with chrValid in cycle t appears in cycle t+1 with wrEn=1, wrData equal to the character, and wrAddr = {buffer index, offset}. The offset counts the characters already stored in the open buffer. No write occurs without chrValid.
- R3: When ctrlEnable is 1 and chrData equals ctrlChar, the character is stored as the last byte of the buffer. The buffer then closes with status bit 0 set.
- R4: A character with any of rxParErr, rxFrmErr or rxBrkErr set is stored and closes the buffer with status bit 1 set. The flags are reported in status bits 4 (parity), 5 (framing) and 6 (break).
- R5: The character that brings the fill to BUF_DEPTH closes the buffer with status bit 2 set and a count of BUF_DEPTH. If several reasons apply to one character, all of their bits are set together.
- R6: When maxIdle is non-zero, the maxIdle-th consecutive idleStrobe closes a non-empty buffer with status bit 3 set and a count equal to the fill. Any character clears the idle run.
- R7: A maxIdle value of 0 disables idle-based closing. The idle run stays at zero.
- R8: When the idle limit is reached on an empty buffer, the buffer does not close and the idle run restarts. No close ever reports a count of zero.
- R9: Every close sets at least one reason bit. The count sits in status bits [ST_CNT+CNT_W-1:ST_CNT], with ST_CNT = 7. closeBufIdx gives the closed buffer. The next buffer index is one higher, wrapping after NUM_BUFS-1, and its offset starts at 0.
- R10: irq pulses in the same cycle as closeValid when intEnable was 1 in the cycle of the close event. Otherwise irq stays at 0.
- R11: If idleStrobe and chrValid are high in the same cycle, the character is taken and the idle strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chrValid | input | 1 | A received character is present |
| chrData | input | DATA_W | Received character |
| rxParErr | input | 1 | Parity error on this character |
| rxFrmErr | input | 1 | Framing error on this character |
| rxBrkErr | input | 1 | Break detected on this character |
| idleStrobe | input | 1 | One idle character time elapsed |
| ctrlEnable | input | 1 | Enables control-character matching |
| ctrlChar | input | DATA_W | Control character value |
| maxIdle | input | IDLE_W | Idle run that closes a buffer; 0 disables |
| intEnable | input | 1 | Interrupt enable (mask) |
| wrEn | output | 1 | Buffer write strobe |
| wrAddr | output | IDX_W+OFF_W | {buffer index, byte offset} |
| wrData | output | DATA_W | Byte to write |
| closeValid | output | 1 | One-cycle buffer close report |
| closeStatus | output | ST_CNT+CNT_W | Reasons, error flags, byte count |
| closeBufIdx | output | IDX_W | Index of the closed buffer |
| irq | output | 1 | Interrupt pulse on close |

## Verification
The bench places a control character at every offset of the buffer. It covers the case where the control character is the filling byte, which must report both the control and full reasons. A design that checked only one reason would drop a bit there. Every combination of error flags is sent at several offsets, so a swapped flag position or a count that is off by one shows up. The idle sweeps cover limits 0 to 4 and fills 0 to 2. They catch a design that reports empty buffers, that keeps counting when the limit is 0, that fails to clear the run on a character, or that counts an idle strobe sent together with a character. The interrupt enable is toggled between closes, and the buffer index is followed across several wraps of the ring.

// File: rtl/rxBufPkg.sv
package rxBufPkg;

  // Status word bit positions (reasons, flags, count)
  localparam int unsigned ST_CTRL = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_FULL = 2;
  localparam int unsigned ST_IDLE = 3;
  localparam int unsigned ST_PAR  = 4;
  localparam int unsigned ST_FRM  = 5;
  localparam int unsigned ST_BRK  = 6;
  localparam int unsigned ST_CNT  = 7;

  // Strobes from control to datapath
  typedef struct packed {
    logic store;
    logic close;
    logic rsnCtrl;
    logic rsnErr;
    logic rsnFull;
    logic rsnIdle;
    logic idleInc;
    logic idleClr;
  } bufStrobes_t;

endpackage

// File: rtl/rxBufControl.sv
module rxBufControl
  import rxBufPkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BUF_DEPTH = 8,
  parameter int unsigned IDLE_W    = 8,
  localparam int unsigned CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic              chrValid,
  input  logic [DATA_W-1:0] chrData,
  input  logic [2:0]        errFlags,
  input  logic              idleStrobe,
  input  logic              ctrlEnable,
  input  logic [DATA_W-1:0] ctrlChar,
  input  logic [IDLE_W-1:0] maxIdle,
  input  logic [CNT_W-1:0]  fillCount,
  input  logic [IDLE_W-1:0] idleCount,
  output bufStrobes_t       strobes
);

  logic isCtrl;
  logic hasErr;
  logic atLastSlot;
  logic idleOn;
  logic idleHit;
  logic bufEmpty;

  assign isCtrl     = ctrlEnable && (chrData == ctrlChar);
  assign hasErr     = |errFlags;
  assign atLastSlot = (fillCount == CNT_W'(BUF_DEPTH - 1));
  assign idleOn     = (maxIdle != '0);
  assign idleHit    = ({1'b0, idleCount} + (IDLE_W+1)'(1)) >= {1'b0, maxIdle};
  assign bufEmpty   = (fillCount == '0);

  always_comb begin
    strobes = '0;
    if (chrValid) begin
      strobes.store   = 1'b1;
      strobes.rsnCtrl = isCtrl;
      strobes.rsnErr  = hasErr;
      strobes.rsnFull = atLastSlot;
      strobes.close   = isCtrl || hasErr || atLastSlot;
      strobes.idleClr = 1'b1;
    end else if (idleStrobe && idleOn) begin
      if (idleHit) begin
        strobes.idleClr = 1'b1;
        if (!bufEmpty) begin
          strobes.close   = 1'b1;
          strobes.rsnIdle = 1'b1;
        end
      end else begin
        strobes.idleInc = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rxBufDatapath.sv
module rxBufDatapath
  import rxBufPkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BUF_DEPTH = 8,
  parameter int unsigned NUM_BUFS  = 4,
  parameter int unsigned IDLE_W    = 8,
  localparam int unsigned CNT_W    = $clog2(BUF_DEPTH + 1),
  localparam int unsigned OFF_W    = $clog2(BUF_DEPTH),
  localparam int unsigned IDX_W    = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int unsigned STAT_W   = ST_CNT + CNT_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  bufStrobes_t            strobes,
  input  logic [DATA_W-1:0]      chrData,
  input  logic [2:0]             errFlags,
  input  logic                   intEnable,
  output logic [CNT_W-1:0]       fillCount,
  output logic [IDLE_W-1:0]      idleCount,
  output logic                   wrEn,
  output logic [IDX_W+OFF_W-1:0] wrAddr,
  output logic [DATA_W-1:0]      wrData,
  output logic                   closeValid,
  output logic [STAT_W-1:0]      closeStatus,
  output logic [IDX_W-1:0]       closeBufIdx,
  output logic                   irq
);

  logic [IDX_W-1:0]  bufIdx;
  logic [IDX_W-1:0]  nextIdx;
  logic [CNT_W-1:0]  closeCount;
  logic [2:0]        repFlags;
  logic [STAT_W-1:0] statusNext;

  assign nextIdx    = (bufIdx == IDX_W'(NUM_BUFS - 1)) ? '0 : bufIdx + 1'b1;
  assign closeCount = strobes.store ? fillCount + 1'b1 : fillCount;
  assign repFlags   = (strobes.store && strobes.rsnErr) ? errFlags : 3'b000;

  always_comb begin
    statusNext                         = '0;
    statusNext[ST_CTRL]                = strobes.rsnCtrl;
    statusNext[ST_ERR]                 = strobes.rsnErr;
    statusNext[ST_FULL]                = strobes.rsnFull;
    statusNext[ST_IDLE]                = strobes.rsnIdle;
    statusNext[ST_PAR]                 = repFlags[0];
    statusNext[ST_FRM]                 = repFlags[1];
    statusNext[ST_BRK]                 = repFlags[2];
    statusNext[ST_CNT +: CNT_W]        = closeCount;
  end

  // Fill, ring index and idle run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= '0;
      bufIdx    <= '0;
      idleCount <= '0;
    end else begin
      if (strobes.close) begin
        fillCount <= '0;
        bufIdx    <= nextIdx;
      end else if (strobes.store) begin
        fillCount <= fillCount + 1'b1;
      end
      if (strobes.idleClr) begin
        idleCount <= '0;
      end else if (strobes.idleInc) begin
        idleCount <= idleCount + 1'b1;
      end
    end
  end

  // Write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrEn <= strobes.store;
      if (strobes.store) begin
        wrAddr <= {bufIdx, fillCount[OFF_W-1:0]};
        wrData <= chrData;
      end
    end
  end

  // Close report and interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      closeValid  <= 1'b0;
      closeStatus <= '0;
      closeBufIdx <= '0;
      irq         <= 1'b0;
    end else begin
      closeValid <= strobes.close;
      irq        <= strobes.close && intEnable;
      if (strobes.close) begin
        closeStatus <= statusNext;
        closeBufIdx <= bufIdx;
      end
    end
  end

endmodule

// File: rtl/rxBufCloser.sv
module rxBufCloser
  import rxBufPkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BUF_DEPTH = 8,
  parameter int unsigned NUM_BUFS  = 4,
  parameter int unsigned IDLE_W    = 8,
  localparam int unsigned CNT_W    = $clog2(BUF_DEPTH + 1),
  localparam int unsigned OFF_W    = $clog2(BUF_DEPTH),
  localparam int unsigned IDX_W    = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int unsigned STAT_W   = ST_CNT + CNT_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   chrValid,
  input  logic [DATA_W-1:0]      chrData,
  input  logic                   rxParErr,
  input  logic                   rxFrmErr,
  input  logic                   rxBrkErr,
  input  logic                   idleStrobe,
  input  logic                   ctrlEnable,
  input  logic [DATA_W-1:0]      ctrlChar,
  input  logic [IDLE_W-1:0]      maxIdle,
  input  logic                   intEnable,
  output logic                   wrEn,
  output logic [IDX_W+OFF_W-1:0] wrAddr,
  output logic [DATA_W-1:0]      wrData,
  output logic                   closeValid,
  output logic [STAT_W-1:0]      closeStatus,
  output logic [IDX_W-1:0]       closeBufIdx,
  output logic                   irq
);

  bufStrobes_t       strobes;
  logic [2:0]        errFlags;
  logic [CNT_W-1:0]  fillCount;
  logic [IDLE_W-1:0] idleCount;

  assign errFlags = {rxBrkErr, rxFrmErr, rxParErr};

  rxBufControl #(
    .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH), .IDLE_W(IDLE_W)
  ) u_ctrl (
    .chrValid(chrValid), .chrData(chrData), .errFlags(errFlags),
    .idleStrobe(idleStrobe), .ctrlEnable(ctrlEnable), .ctrlChar(ctrlChar),
    .maxIdle(maxIdle), .fillCount(fillCount), .idleCount(idleCount),
    .strobes(strobes)
  );

  rxBufDatapath #(
    .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH), .NUM_BUFS(NUM_BUFS), .IDLE_W(IDLE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .chrData(chrData),
    .errFlags(errFlags), .intEnable(intEnable), .fillCount(fillCount),
    .idleCount(idleCount), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .closeValid(closeValid), .closeStatus(closeStatus),
    .closeBufIdx(closeBufIdx), .irq(irq)
  );

endmodule

// File: rtl/rxBufCloserChk.sv
module rxBufCloserChk
  import rxBufPkg::*;
#(
  parameter int unsigned BUF_DEPTH = 8,
  parameter int unsigned STAT_W    = 11,
  localparam int unsigned CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              chrValid,
  input logic              idleStrobe,
  input logic              wrEn,
  input logic              closeValid,
  input logic [STAT_W-1:0] closeStatus,
  input logic              irq
);

  logic [CNT_W-1:0] repCount;
  assign repCount = closeStatus[ST_CNT +: CNT_W];

  AST_IRQ_NEEDS_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> closeValid); // R10
  AST_NO_EMPTY_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    closeValid |-> (repCount != '0)); // R8
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    closeValid |-> (repCount <= CNT_W'(BUF_DEPTH))); // R5
  AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (closeValid && closeStatus[ST_FULL]) |-> (repCount == CNT_W'(BUF_DEPTH))); // R5
  AST_WRITE_FROM_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(chrValid)); // R2
  AST_IDLE_CLOSE_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (closeValid && closeStatus[ST_IDLE]) |-> ($past(idleStrobe) && !$past(chrValid))); // R11
  AST_REASON_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    closeValid |-> (closeStatus[3:0] != 4'b0000)); // R9

endmodule

bind rxBufCloser rxBufCloserChk #(
  .BUF_DEPTH(BUF_DEPTH), .STAT_W(STAT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .chrValid(chrValid), .idleStrobe(idleStrobe),
  .wrEn(wrEn), .closeValid(closeValid), .closeStatus(closeStatus), .irq(irq)
);

// File: tb/rxBufCloser_tb.sv
module rxBufCloser_tb;

  localparam int DEPTH = 8;
  localparam int NBUF  = 4;
  localparam int IW    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chrValid = 1'b0;
  logic [7:0] chrData = '0;
  logic rxParErr = 1'b0, rxFrmErr = 1'b0, rxBrkErr = 1'b0;
  logic idleStrobe = 1'b0;
  logic ctrlEnable = 1'b0;
  logic [7:0] ctrlChar = 8'h0D;
  logic [IW-1:0] maxIdle = '0;
  logic intEnable = 1'b0;
  logic wrEn;
  logic [4:0] wrAddr;
  logic [7:0] wrData;
  logic closeValid;
  logic [10:0] closeStatus;
  logic [1:0] closeBufIdx;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  int mFill = 0;
  int mBuf = 0;
  int mIdle = 0;

  always #2 clk = ~clk;

  rxBufCloser #(.DATA_W(8), .BUF_DEPTH(DEPTH), .NUM_BUFS(NBUF), .IDLE_W(IW)) u_dut (
    .clk(clk), .rstN(rstN), .chrValid(chrValid), .chrData(chrData),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .rxBrkErr(rxBrkErr),
    .idleStrobe(idleStrobe), .ctrlEnable(ctrlEnable), .ctrlChar(ctrlChar),
    .maxIdle(maxIdle), .intEnable(intEnable), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .closeValid(closeValid), .closeStatus(closeStatus),
    .closeBufIdx(closeBufIdx), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One cycle of stimulus; model computes the outcome visible after the edge.
  task automatic step(input bit v, input int d, input int e, input bit idl, input string tag);
    bit close = 0, rc = 0, re = 0, rf = 0, ri = 0;
    int cnt = 0, flags = 0, expAddr, expStat, closedBuf;
    expAddr = mBuf * DEPTH + mFill;
    closedBuf = mBuf;
    if (v) begin
      rc = ctrlEnable && (d == int'(ctrlChar));
      re = (e != 0);
      rf = (mFill + 1 == DEPTH);
      close = rc | re | rf;
      cnt = mFill + 1;
      flags = re ? e : 0;
      mIdle = 0;
      mFill = close ? 0 : mFill + 1;
    end else if (idl && maxIdle != 0) begin
      if (mIdle + 1 >= int'(maxIdle)) begin
        mIdle = 0;
        if (mFill != 0) begin
          close = 1; ri = 1; cnt = mFill; mFill = 0;
        end
      end else begin
        mIdle++;
      end
    end
    if (close) mBuf = (mBuf + 1) % NBUF;
    expStat = (cnt << 7) | (flags << 4) | (int'(ri) << 3) | (int'(rf) << 2) | (int'(re) << 1) | int'(rc);
    chrValid = v; chrData = 8'(d);
    {rxBrkErr, rxFrmErr, rxParErr} = 3'(e);
    idleStrobe = idl;
    @(posedge clk); #1;
    chk(tag, "wrEn", int'(wrEn), int'(v));
    if (v) begin
      chk("R2", "wrAddr", int'(wrAddr), expAddr);
      chk("R2", "wrData", int'(wrData), d);
    end
    chk(tag, "closeValid", int'(closeValid), int'(close));
    if (close) begin
      chk(tag, "closeStatus", int'(closeStatus), expStat);
      chk("R9", "closeBufIdx", int'(closeBufIdx), closedBuf);
    end
    chk("R10", "irq", int'(irq), int'(close && intEnable));
    chrValid = 0; idleStrobe = 0; {rxBrkErr, rxFrmErr, rxParErr} = 3'b000;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL R0 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "wrEn in reset", int'(wrEn), 0);
    chk("R1", "closeValid in reset", int'(closeValid), 0);
    chk("R1", "irq in reset", int'(irq), 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1", "wrEn after reset", int'(wrEn), 0);
    chk("R1", "closeValid after reset", int'(closeValid), 0);

    // R5: plain fills across the ring (also R1: first address in buffer 0)
    intEnable = 1;
    for (int r = 0; r < 5; r++)
      for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + i, 0, 0, "R5");

    // R3: control character at every offset
    ctrlEnable = 1;
    for (int p = 0; p < DEPTH; p++) begin
      for (int i = 0; i < p; i++) step(1, 8'h20 + i, 0, 0, "R2");
      step(1, 8'h0D, 0, 0, "R3");
    end
    ctrlEnable = 0;
    step(1, 8'h0D, 0, 0, "R3");
    ctrlEnable = 1;
    step(1, 8'h0D, 0, 0, "R3");

    // R4: every error flag combination at several offsets
    for (int e = 1; e < 8; e++)
      for (int p = 0; p < 3; p++) begin
        for (int i = 0; i < p; i++) step(1, 8'h40 + i, 0, 0, "R2");
        step(1, 8'h55, e, 0, "R4");
      end

    // R6 / R7 / R8: idle limits and fill levels
    for (int mi = 0; mi < 5; mi++) begin
      maxIdle = IW'(mi);
      for (int f = 0; f < 3; f++) begin
        for (int i = 0; i < f; i++) step(1, 8'h60 + i, 0, 0, "R2");
        for (int k = 0; k < 6; k++)
          step(0, 0, 0, 1, (mi == 0) ? "R7" : ((f == 0) ? "R8" : "R6"));
      end
    end

    // R6: a character clears the idle run
    maxIdle = 3;
    step(1, 8'h70, 0, 0, "R6");
    step(0, 0, 0, 1, "R6");
    step(0, 0, 0, 1, "R6");
    step(1, 8'h71, 0, 0, "R6");
    step(0, 0, 0, 1, "R6");
    step(0, 0, 0, 1, "R6");
    step(0, 0, 0, 1, "R6");

    // R11: idle with a character in the same cycle is ignored
    maxIdle = 2;
    step(1, 8'h72, 0, 1, "R11");
    step(1, 8'h73, 0, 1, "R11");
    step(0, 0, 0, 1, "R11");
    step(0, 0, 0, 1, "R11");

    // R10: interrupt enable toggled between closes
    for (int k = 0; k < 8; k++) begin
      intEnable = k[0];
      step(1, 8'h30 + k, 0, 0, "R2");
      step(1, 8'h0D, 0, 0, "R10");
    end

    step(0, 0, 0, 0, "R2");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule